// File: doc/BRIEF.md
# Infrared Mark/Period Capture Receiver

This block timestamps the symbols of a demodulated remote-control signal. The input pin, already synchronous to the system clock and free of carrier, is sampled on a tick that comes from dividing the system clock by a programmable integer. The divisor is normally chosen so that ticks arrive at about 10 MHz. For each symbol the block counts two values in ticks. The first is the mark, the number of ticks the signal is active. The second is the period, the number of ticks from the first active tick of this symbol to the first active tick of the next one.

Each (mark, period) pair goes into an eight-entry capture FIFO. When no new mark begins within a programmable maximum period, the open symbol is closed with the period code 0xFFFF, which signals the end of a train. Software works through a small register port. It sets enable, input inversion, divisor and maximum period, reads pairs from the FIFO, and services four sticky event flags through an enable mask and a write-one-to-clear register. A single interrupt line summarises the enabled flags.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset: CTRL (addr 0) reads 0, DIV (addr 1) reads 1, MAXPER (addr 2) reads 0x5000, IEN (addr 3), ISTAT (addr 4) and RXSTAT (addr 6) read 0, the FIFO is empty and irq is 0.
- R2: While enabled, one sample tick occurs every DIV clock cycles (a DIV of 0 acts as 1). Writing DIV restarts the tick phase, and all measurements are in ticks.
- R3: A mark starts on a tick where the polarity-corrected input is 1 and was 0 on the previous tick. When the next mark starts, the pair (mark = active ticks from the mark start, period = ticks from that start up to this next one) is pushed.
- R4: If an open symbol's period count reaches MAXPER with no new mark, the pair (mark, 0xFFFF) is pushed and the symbol is closed.
- R5: CTRL bit 1 = 0 treats a high pin as active, and CTRL bit 1 = 1 treats a low pin as active.
- R6: CTRL bit 0 enables capture. While it is 0, nothing is pushed and an open symbol is dropped.
- R7: The FIFO holds 8 pairs in arrival order. Reading MARK (addr 7) returns the oldest mark without removing it. Reading PERIOD (addr 8) returns the oldest period and removes the pair.
- R8: A pair arriving while the FIFO holds 8 entries is discarded and sets the overrun flag.
- R9: ISTAT flags are sticky: bit 0 pair stored, bit 1 timeout pair stored, bit 2 overrun, bit 3 FIFO became full. Writing ICLR (addr 5) with a 1 in a bit position clears that flag.
- R10: RXSTAT bits 15:8 hold the FIFO entry count, and bit 2 mirrors the overrun flag.
- R11: irq is 1 exactly when some ISTAT bit and the same IEN bit are both 1.
- R12: Mark and period counts stop at 0xFFFE, so a measured value never equals the 0xFFFF timeout code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Demodulated receiver input, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a PERIOD read pops) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench takes the value 1 ns after raising the read strobe at a falling edge, and any pop lands on the following rising edge. A pair enters the FIFO, with its ISTAT flags and irq, on the same rising edge as the tick that sees the next mark start or the timeout. Every pin level is held for a whole number of falling-to-falling windows, so the expected tick counts follow directly from the hold lengths and DIV. Timeout results are read only after a wait well beyond MAXPER ticks.

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture #(
  parameter int DEPTH      = 8,
  parameter int DW         = 16,
  parameter int DIV_RST    = 1,
  parameter int MAXPER_RST = 'h5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_pin,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [DW-1:0] SAT  = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] TOUT = '1;
  localparam logic [3:0] A_CTRL = 4'd0, A_DIV = 4'd1, A_MAXP = 4'd2, A_IEN = 4'd3,
                         A_IST = 4'd4, A_ICLR = 4'd5, A_RXST = 4'd6, A_MARK = 4'd7,
                         A_PER = 4'd8;

  logic          en_q, inv_q;
  logic [DW-1:0] div_q, maxp_q;
  logic [3:0]    ien_q, ist_q;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_div  = reg_wr && reg_addr == A_DIV;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      inv_q  <= 1'b0;
      div_q  <= DW'(DIV_RST);
      maxp_q <= DW'(MAXPER_RST);
      ien_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin en_q <= reg_wdata[0]; inv_q <= reg_wdata[1]; end
        A_DIV:  div_q  <= reg_wdata;
        A_MAXP: maxp_q <= reg_wdata;
        A_IEN:  ien_q  <= reg_wdata[3:0];
        default: ;
      endcase
    end

  // sample tick
  logic [DW-1:0] tcnt;
  wire [DW-1:0] div_eff = (div_q == '0) ? DW'(1) : div_q;
  wire tick = en_q && (tcnt == div_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 tcnt <= '0;
    else if (!en_q || wr_div || tick) tcnt <= '0;
    else                        tcnt <= tcnt + 1'b1;

  // measurement
  logic          prev_q, act_q, inm_q;
  logic [DW-1:0] mcnt, pcnt;
  wire lvl   = rx_pin ^ inv_q;
  wire start = tick && lvl && !prev_q;
  wire tmo   = tick && !start && act_q && (pcnt >= maxp_q);
  wire push  = (start && act_q) || tmo;
  wire [DW-1:0] push_per = tmo ? TOUT : pcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b0; act_q <= 1'b0; inm_q <= 1'b0;
      mcnt   <= '0;   pcnt  <= '0;
    end else if (!en_q || wr_ctrl && !reg_wdata[0]) begin
      prev_q <= 1'b0; act_q <= 1'b0; inm_q <= 1'b0;
    end else if (tick) begin
      prev_q <= lvl;
      if (start) begin
        act_q <= 1'b1; inm_q <= 1'b1;
        mcnt  <= DW'(1); pcnt <= DW'(1);
      end else if (tmo) begin
        act_q <= 1'b0; inm_q <= 1'b0;
      end else if (act_q) begin
        if (pcnt != SAT) pcnt <= pcnt + 1'b1;
        if (inm_q && lvl) begin
          if (mcnt != SAT) mcnt <= mcnt + 1'b1;
        end else inm_q <= 1'b0;
      end
    end

  // capture fifo
  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] mem_p [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  wire full  = cnt == CW'(DEPTH);
  wire pop   = reg_rd && reg_addr == A_PER && cnt != '0;
  wire wr_ok = push && !full;

  always_ff @(posedge clk) if (wr_ok) begin
    mem_m[wp] <= mcnt;
    mem_p[wp] <= push_per;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(pop);
    end

  // status and interrupt
  wire [3:0] ev  = {wr_ok && cnt == CW'(DEPTH-1) && !pop, push && full, wr_ok && tmo, wr_ok};
  wire [3:0] clr = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[3:0] : 4'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ist_q <= '0;
    else        ist_q <= (ist_q & ~clr) | ev;

  assign irq = |(ist_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = DW'({inv_q, en_q});
      A_DIV:  reg_rdata = div_q;
      A_MAXP: reg_rdata = maxp_q;
      A_IEN:  reg_rdata = DW'(ien_q);
      A_IST:  reg_rdata = DW'(ist_q);
      A_RXST: reg_rdata = (DW'(cnt) << 8) | DW'({ist_q[2], 2'b00});
      A_MARK: reg_rdata = (cnt != '0) ? mem_m[rp] : '0;
      A_PER:  reg_rdata = (cnt != '0) ? mem_p[rp] : '0;
      default: ;
    endcase
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> cnt == $past(cnt)); // R8
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ist_q[2]); // R8
  AST_NO_FALSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (mcnt != TOUT && (tmo || pcnt != TOUT))); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !push); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ICLR && reg_wdata[3:0] == 4'hF && !push) |=> ist_q == 4'h0); // R9
endmodule

// File: tb/ir_pulse_capture_test.sv
module ir_pulse_capture_test;
  logic clk = 0, rst_n = 0, rx_pin = 0, reg_wr = 0, reg_rd = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic irq;
  int vecs = 0, bad = 0;
  bit done = 0;

  ir_pulse_capture uut (.clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  always #2 clk = ~clk;

  localparam int NV = 6;
  localparam int VT [NV][2] = '{'{4,6}, '{2,9}, '{7,3}, '{1,1}, '{10,20}, '{5,5}};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic hold(logic l, int n);
    rx_pin = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic popchk(string req, logic [15:0] m, logic [15:0] p);
    rdchk(req, 4'd7, m);
    rdchk(req, 4'd8, p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdchk("R1 ctrl", 4'd0, 16'h0);
    rdchk("R1 div", 4'd1, 16'h1);
    rdchk("R1 maxper", 4'd2, 16'h5000);
    rdchk("R1 ien", 4'd3, 16'h0);
    rdchk("R1 istat", 4'd4, 16'h0);
    rdchk("R1 rxstat", 4'd6, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // vector table: train, high = active (R3, R5)
    wr(4'd2, 16'd60);
    wr(4'd3, 16'h0002);
    wr(4'd0, 16'h0001);
    for (int i = 0; i < NV; i++) begin
      hold(1, VT[i][0]);
      hold(0, VT[i][1]);
    end
    hold(1, 3);
    hold(0, 100);
    rdchk("R10 count", 4'd6, 16'h0700);
    rdchk("R9 flags", 4'd4, 16'h0003);
    chk("R11 irq on last", {15'h0, irq}, 16'h1);
    for (int i = 0; i < NV; i++)
      popchk("R3 pair", 16'(VT[i][0]), 16'(VT[i][0] + VT[i][1]));
    popchk("R4 timeout", 16'd3, 16'hFFFF);
    rdchk("R7 empty", 4'd6, 16'h0000);
    wr(4'd5, 16'h000F);
    rdchk("R9 clear", 4'd4, 16'h0000);
    chk("R11 irq cleared", {15'h0, irq}, 16'h0);

    // R5 inverted polarity: low is active
    wr(4'd0, 16'h0000);
    rx_pin = 1;
    wr(4'd0, 16'h0003);
    hold(0, 5); hold(1, 7); hold(0, 2); hold(1, 80);
    popchk("R5 inverted", 16'd5, 16'd12);
    popchk("R5 inverted tmo", 16'd2, 16'hFFFF);

    // R6 disabled: toggling ignored
    wr(4'd0, 16'h0000);
    for (int i = 0; i < 5; i++) begin hold(1, 3); hold(0, 3); end
    rdchk("R6 nothing stored", 4'd6, 16'h0000);

    // R2 divisor 4
    wr(4'd5, 16'h000F);
    wr(4'd1, 16'd4);
    wr(4'd0, 16'h0001);
    hold(1, 12); hold(0, 20); hold(1, 12); hold(0, 280);
    popchk("R2 div4", 16'd3, 16'd8);
    popchk("R2 div4 tmo", 16'd3, 16'hFFFF);

    // R8 overrun with full FIFO
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd1);
    wr(4'd5, 16'h000F);
    wr(4'd3, 16'h0000);
    wr(4'd0, 16'h0001);
    for (int i = 1; i <= 9; i++) begin hold(1, i); hold(0, 3); end
    hold(1, 1);
    wr(4'd0, 16'h0000);
    rdchk("R8 count full", 4'd6, 16'h0804);
    rdchk("R9 full+ovr", 4'd4, 16'h000D);
    chk("R11 masked irq", {15'h0, irq}, 16'h0);
    for (int i = 1; i <= 8; i++)
      popchk("R7 order", 16'(i), 16'(i + 3));
    rdchk("R10 ovr persists", 4'd6, 16'h0004);
    wr(4'd5, 16'h0004);
    rdchk("R10 ovr cleared", 4'd6, 16'h0000);

    // R12 saturation
    wr(4'd5, 16'h000F);
    wr(4'd2, 16'hFFFF);
    wr(4'd0, 16'h0001);
    hold(1, 65540); hold(0, 5); hold(1, 2);
    wr(4'd0, 16'h0000);
    popchk("R12 saturate", 16'hFFFE, 16'hFFFE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule